// File: doc/BRIEF.md
# Stochastic Signal Density Modulator

The block turns a programmed density value into a one-bit stream whose long-run duty equals that density divided by the period of a pseudo-random sequence. A modular (Galois) linear feedback shift register steps through the non-zero codes of an n-bit space in scrambled order. On every clock its present state is compared with a density register, and the registered result drives the output. Because the high and low cycles are spread pseudo-randomly over the period rather than grouped into one pulse, the output spectrum is flat. That suits LED dimming and simple one-bit DACs.

Software sets up the block through a small write port. It programs the feedback polynomial and a control word, which holds the resolution, the compare mode, the interrupt enable and a start bit. While the block is stopped, a density write also seeds the shift register. Once the block is running, a density write changes only the compare threshold. A compare-true interrupt is given as a registered pulse.

Top module: `ssd_modulator`

## Requirements
- R1: A synchronous reset clears the polynomial, density and control registers, stops the block, and drives `mod_out` and `irq` low at the first sampled edge after reset.
- R2: Writes take effect at the rising clock edge where `wr_en` is high. For `wr_sel` 0, `wr_data` is the polynomial. For `wr_sel` 1, it is the density. For `wr_sel` 2, it is the control word: bit 0 start, bit 1 compare mode (0 = less-or-equal, 1 = less-than), bit 2 interrupt enable, bits 13:8 resolution n. A resolution below 2 acts as 2, and one above `W` acts as `W`.
- R3: While running, the state steps once per clock. If bit 0 of the state is 1, the next state is the state shifted right by one, XORed with the polynomial. Otherwise it is the state shifted right by one. With a maximal polynomial, every value from 1 to 2^n−1 appears once per 2^n−1 cycles. In less-or-equal mode with density d, `mod_out` is therefore high on exactly d cycles of every period.
- R4: In less-than mode with density d ≥ 1, `mod_out` is high on exactly d−1 cycles of every period. With d = 0 it is never high.
- R5: Density bits at and above position n are ignored. For example, 255 at n = 7 behaves as 127.
- R6: A density write while stopped loads the masked value into the shift register as the seed. A density write while running changes only the compare threshold, and the sequence continues undisturbed.
- R7: A zero seed is replaced by 1, so the register never locks up in the all-zero state.
- R8: While stopped, `mod_out` is low. The output is registered, so it reflects the state and threshold of the previous cycle.
- R9: `irq` pulses high for one cycle for each cycle in which the compare is true while the block is running and the interrupt is enabled. With the enable clear, `irq` stays low.
- R10: Clearing the start bit freezes the sequence, and `mod_out` is low from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 polynomial, 1 density, 2 control |
| wr_data | input | W | Write data |
| mod_out | output | 1 | Modulated one-bit stream |
| irq | output | 1 | Compare-true interrupt pulse |

## Verification
The bench counts high output cycles over exactly one full period for several resolutions, polynomials and densities in both compare modes. A design with a faulty step rule or a lost code would miss the exact counts d or d−1, and one off by one in the compare would swap the two modes. Another test seeds with zero while stopped and then rewrites the density while running, and checks the exact bit pattern that follows. A design that locks at zero would output constant ones, and one that reseeds on a running write would shift the pattern. Further tests cover the density mask at a reduced resolution, the low output while stopped or after a stop, and the absence of interrupts with the enable clear.

// File: rtl/ssd_modulator.sv
module ssd_modulator #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         mod_out,
  output logic         irq
);
  localparam int RW = $clog2(W + 1);
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0]  poly_q, dens_q, shift_q;
  logic [RW-1:0] res_q, res_eff;
  logic          run_q, lt_q, ie_q, out_q, irq_q;
  logic [W-1:0]  mask, dens_m, step, seed;
  logic          hit;

  assign res_eff = (res_q < RW'(2)) ? RW'(2) : (res_q > RW'(W)) ? RW'(W) : res_q;
  assign mask    = ALL1 >> (RW'(W) - res_eff);
  assign dens_m  = dens_q & mask;
  assign step    = ((shift_q >> 1) ^ (shift_q[0] ? poly_q : '0)) & mask;
  assign seed    = ((wr_data & mask) == '0) ? W'(1) : (wr_data & mask);
  assign hit     = lt_q ? (shift_q < dens_m) : (shift_q <= dens_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      poly_q  <= '0;
      dens_q  <= '0;
      shift_q <= W'(1);
      res_q   <= '0;
      run_q   <= 1'b0;
      lt_q    <= 1'b0;
      ie_q    <= 1'b0;
      out_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      out_q <= run_q & hit;
      irq_q <= run_q & ie_q & hit;
      if (run_q) shift_q <= step;
      if (wr_en) begin
        case (wr_sel)
          2'd0: poly_q <= wr_data;
          2'd1: begin
            dens_q <= wr_data;
            if (!run_q) shift_q <= seed;
          end
          2'd2: begin
            run_q <= wr_data[0];
            lt_q  <= wr_data[1];
            ie_q  <= wr_data[2];
            res_q <= wr_data[8 +: RW];
          end
          default: ;
        endcase
      end
    end
  end

  assign mod_out = out_q;
  assign irq     = irq_q;
endmodule

module ssd_modulator_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic         run,
  input logic         ie,
  input logic [W-1:0] shift,
  input logic [W-1:0] dens,
  input logic         mod_out,
  input logic         irq
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!mod_out && !irq));
  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst) !run |=> !mod_out);
  p_irq_needs_out_r9: assert property (@(posedge clk) disable iff (rst) irq |-> mod_out);
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst) !ie |=> !irq);
  p_no_lockup_r7: assert property (@(posedge clk) disable iff (rst) run |-> (shift != '0));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && wr_sel == 2'd1)) |=> $stable(shift));
  p_dens_load_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1) |=> (dens == $past(wr_data)));
endmodule

bind ssd_modulator ssd_modulator_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .run(run_q), .ie(ie_q), .shift(shift_q), .dens(dens_q),
  .mod_out(mod_out), .irq(irq)
);

// File: tb/tb_ssd_modulator.sv
module tb_ssd_modulator;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NV = 9;

  localparam int V_RES [NV] = '{2, 3, 4, 8, 8, 8, 7, 5, 16};
  localparam int V_POLY[NV] = '{32'h3, 32'h6, 32'hC, 32'hB8, 32'hB8, 32'hB8, 32'h72, 32'h1E, 32'hD008};
  localparam int V_DENS[NV] = '{2, 5, 15, 32'h50, 32'h50, 0, 255, 1, 32'h1020};
  localparam int V_LT  [NV] = '{0, 1, 0, 0, 1, 0, 0, 1, 0};
  localparam int V_EXP [NV] = '{2, 4, 15, 80, 79, 0, 127, 0, 4128};

  logic clk = 1'b0;
  logic rst, wr_en;
  logic [1:0] wr_sel;
  logic [W-1:0] wr_data;
  logic mod_out, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  ssd_modulator #(.W(W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mod_out(mod_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  function automatic logic [W-1:0] ctrl(input int res, input int lt, input int ie, input int go);
    return (W'(res) << 8) | (W'(ie) << 2) | (W'(lt) << 1) | W'(go);
  endfunction

  initial begin
    #(CLK_PERIOD * 300000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ones, irqs, bad;
    int pat [9];
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 mod_out after reset", int'(mod_out), 0);
    check("R1 irq after reset", int'(irq), 0);
    @(negedge clk); rst = 1'b0;

    // R8: stopped, outputs stay low
    wr(2'd2, ctrl(4, 0, 1, 0));
    wr(2'd0, 32'hC);
    wr(2'd1, 32'h7);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (mod_out) bad++;
    end
    check("R8 stopped output high cycles", bad, 0);

    // R3 R4 R5 R2: full-period density table
    for (int v = 0; v < NV; v++) begin
      int per;
      per = (1 << V_RES[v]) - 1;
      wr(2'd2, ctrl(V_RES[v], V_LT[v], 1, 0));
      wr(2'd0, W'(V_POLY[v]));
      wr(2'd1, W'(V_DENS[v]));
      wr(2'd2, ctrl(V_RES[v], V_LT[v], 1, 1));
      ones = 0; irqs = 0;
      for (int c = 0; c < per; c++) begin
        @(posedge clk); #1;
        ones += int'(mod_out);
        irqs += int'(irq);
      end
      check($sformatf("R3/R4/R5 vector %0d ones per period", v), ones, V_EXP[v]);
      check($sformatf("R9 vector %0d irq pulses per period", v), irqs, V_EXP[v]);
    end

    // R9: interrupt disabled
    wr(2'd2, ctrl(8, 0, 0, 0));
    wr(2'd0, 32'hB8);
    wr(2'd1, 32'h50);
    wr(2'd2, ctrl(8, 0, 0, 1));
    ones = 0; irqs = 0;
    for (int c = 0; c < 255; c++) begin
      @(posedge clk); #1;
      ones += int'(mod_out);
      irqs += int'(irq);
    end
    check("R9 irq with enable clear", irqs, 0);
    check("R3 ones with enable clear", ones, 80);

    // R6 R7: zero seed forced to 1, running write leaves sequence alone
    wr(2'd2, ctrl(3, 0, 1, 0));
    wr(2'd0, 32'h6);
    wr(2'd1, 32'h0);
    wr(2'd2, ctrl(3, 0, 1, 1));
    wr(2'd1, 32'h2);
    pat = '{0, 0, 0, 0, 0, 0, 1, 1, 0};
    bad = 0;
    for (int i = 0; i < 9; i++) begin
      if (i > 0) begin @(posedge clk); #1; end
      if (int'(mod_out) != pat[i]) bad++;
    end
    check("R6/R7 pattern mismatches after zero seed", bad, 0);

    // R10: stop
    wr(2'd1, 32'h7);
    wr(2'd2, ctrl(3, 0, 1, 0));
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (mod_out || irq) bad++;
    end
    check("R10 output after stop", bad, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule